// File: doc/BRIEF.md
# Channel Clock Divider

This block divides one fast input clock down to a channel output clock. Two separate count fields set how many input cycles the output spends high and how many it spends low. One count pair therefore sets both the division ratio and the duty cycle. A configuration input set shapes the output further:
- a pass-through mode that routes the input clock straight to the output;
- a static-high override;
- a choice of starting level;
- a programmable phase delay after restart;
- a half-cycle duty-cycle correction for odd periods.

A chip-level restart strobe brings all channels to a known phase. Each channel can be told to ignore that strobe. The static-high override is only honoured while the channel ignores the strobe.

The block has one module. All sequential logic runs on the rising edge of the input clock, except one falling-edge flop used for duty-cycle correction. Count changes are applied at the end of each low phase, so a reprogrammed divider never emits a pulse of mixed length.

Top module: `clkdiv_channel`

## Requirements
- R1: After the asynchronous active-low reset, the output is low and the stored counts are zero. Without a restart, the output then toggles on every rising input edge.
- R2: A high phase lasts hi_cycles+1 input cycles.
- R3: A low phase lasts lo_cycles+1 input cycles.
- R4: With bypass=1, the output equals the input clock, and the divider state is frozen. Bypass takes priority over the static-high override.
- R5: When sync_req is 1 at a rising edge and no_sync is 0, the output goes to the start level at that edge. All counts restart and both count fields are captured.
- R6: With no_sync=1, sync_req has no effect on the output.
- R7: With force_hi=1 and no_sync=1 (and bypass=0), the output is static high. With no_sync=0, force_hi has no effect.
- R8: start_hi=1 makes the first phase after a restart high; start_hi=0 makes it low.
- R9: Counted from the last rising edge at which the restart is sampled, the first phase lasts phase_ofs + N cycles, where N is the programmed length of that phase (count+1).
- R10: When dcc_off=0 and the captured hi+lo is odd (odd period), the output stays high for the first half input cycle after each high-to-low transition. When dcc_off=1 or the period is even, the phase lengths are exact.
- R11: New count values written during operation are captured only at the end of a low phase. The phase in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_req | input | 1 | Chip-level restart strobe, active high |
| hi_cycles | input | CW | High phase length minus one |
| lo_cycles | input | CW | Low phase length minus one |
| bypass | input | 1 | 1: route input clock to output |
| no_sync | input | 1 | 1: ignore sync_req |
| force_hi | input | 1 | 1: static high output when no_sync=1 |
| start_hi | input | 1 | Level of first phase after restart |
| phase_ofs | input | CW | Extra input cycles before the first edge after restart |
| dcc_off | input | 1 | 1: disable duty-cycle correction |
| clk_out | output | 1 | Divided channel clock |

## Verification
Two functions can meet in the same cycle:
- A restart can land just as a low phase ends and new counts are due to be captured. The restart must win. The bench provokes this by pulsing sync_req at many offsets into a running pattern. A behavioural reference then judges every half cycle.
- The half-cycle correction can fall on the same transition that a restart forces from high to low. The bench covers this by restarting with an odd period and start_hi=0 while the output is high. The reference expects the stretched half cycle there too.

// File: rtl/clkdiv_channel.sv
module clkdiv_channel #(
  parameter int CW = 4
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          sync_req,
  input  logic [CW-1:0] hi_cycles,
  input  logic [CW-1:0] lo_cycles,
  input  logic          bypass,
  input  logic          no_sync,
  input  logic          force_hi,
  input  logic          start_hi,
  input  logic [CW-1:0] phase_ofs,
  input  logic          dcc_off,
  output logic          clk_out
);

  logic          lvl, lvl_neg;
  logic [CW-1:0] cnt, dly, hi_l, lo_l;

  wire           sync_go = sync_req & ~no_sync;
  wire [CW-1:0]  cur_len = lvl ? hi_l : lo_l;
  wire           dcc_en  = ~dcc_off & (hi_l[0] ^ lo_l[0]);
  wire           div_out = lvl | (dcc_en & lvl_neg);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      lvl  <= 1'b0;
      cnt  <= '0;
      dly  <= '0;
      hi_l <= '0;
      lo_l <= '0;
    end else if (!bypass) begin
      if (sync_go) begin
        lvl  <= start_hi;
        cnt  <= '0;
        dly  <= phase_ofs;
        hi_l <= hi_cycles;
        lo_l <= lo_cycles;
      end else if (dly != '0) begin
        dly <= dly - CW'(1);
      end else if (cnt == cur_len) begin
        cnt <= '0;
        lvl <= ~lvl;
        if (!lvl) begin
          hi_l <= hi_cycles;
          lo_l <= lo_cycles;
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // falling-edge copy used to widen the high phase by half a cycle
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) lvl_neg <= 1'b0;
    else        lvl_neg <= lvl;
  end

  assign clk_out = bypass ? clk_in : ((force_hi & no_sync) ? 1'b1 : div_out);

endmodule

// File: rtl/clkdiv_channel_chk.sv
module clkdiv_channel_chk #(
  parameter int CW = 4
) (
  input logic          clk_in,
  input logic          rst_n,
  input logic          sync_req,
  input logic          bypass,
  input logic          no_sync,
  input logic          force_hi,
  input logic          start_hi,
  input logic          clk_out,
  input logic          lvl,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] dly,
  input logic [CW-1:0] hi_l,
  input logic [CW-1:0] lo_l
);

  a_r7_forced_high: assert property (@(posedge clk_in) disable iff (!rst_n)
    (no_sync && force_hi && !bypass) |-> clk_out);

  a_r5_sync_start_level: assert property (@(posedge clk_in) disable iff (!rst_n)
    (sync_req && !no_sync && !bypass) |=> (lvl == $past(start_hi)));

  a_r4_bypass_freeze: assert property (@(posedge clk_in) disable iff (!rst_n)
    bypass |=> ($stable(cnt) && $stable(lvl) && $stable(dly)));

  a_r9_offset_holds_level: assert property (@(posedge clk_in) disable iff (!rst_n)
    (dly != '0 && !(sync_req && !no_sync) && !bypass) |=> $stable(lvl));

  a_r2_count_in_range: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt <= (lvl ? hi_l : lo_l));

  a_r6_nosync_no_restart: assert property (@(posedge clk_in) disable iff (!rst_n)
    (no_sync && !bypass && dly == '0 && cnt != (lvl ? hi_l : lo_l)) |=> $stable(lvl));

endmodule

bind clkdiv_channel clkdiv_channel_chk #(.CW(CW)) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .sync_req(sync_req), .bypass(bypass),
  .no_sync(no_sync), .force_hi(force_hi), .start_hi(start_hi),
  .clk_out(clk_out), .lvl(lvl), .cnt(cnt), .dly(dly), .hi_l(hi_l), .lo_l(lo_l)
);

// File: tb/tb_clkdiv_channel.sv
`timescale 1ns/1ps
module tb_clkdiv_channel;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_req = 1'b0, bypass = 1'b0, no_sync = 1'b0, force_hi = 1'b0;
  logic start_hi = 1'b0, dcc_off = 1'b1;
  logic [CW-1:0] hi_cycles = '0, lo_cycles = '0, phase_ofs = '0;
  logic clk_out;

  always #2.5 clk = ~clk;

  clkdiv_channel #(.CW(CW)) dut (
    .clk_in(clk), .rst_n(rst_n), .sync_req(sync_req), .hi_cycles(hi_cycles),
    .lo_cycles(lo_cycles), .bypass(bypass), .no_sync(no_sync), .force_hi(force_hi),
    .start_hi(start_hi), .phase_ofs(phase_ofs), .dcc_off(dcc_off), .clk_out(clk_out)
  );

  int total = 0, bad = 0;
  string tag = "R1";
  bit chk_en = 1'b0;

  // behavioural reference: level plus cycles left in the current phase
  bit m_lvl, m_prev;
  int left;
  int m_hi, m_lo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_prev = 0; left = 1; m_hi = 0; m_lo = 0;
    end else begin
      m_prev = m_lvl;
      if (!bypass) begin
        if (sync_req && !no_sync) begin
          m_lvl = start_hi; m_hi = hi_cycles; m_lo = lo_cycles;
          left = int'(phase_ofs) + (start_hi ? m_hi : m_lo) + 1;
        end else begin
          left--;
          if (left == 0) begin
            m_lvl = !m_lvl;
            if (m_lvl) begin m_hi = hi_cycles; m_lo = lo_cycles; end
            left = (m_lvl ? m_hi : m_lo) + 1;
          end
        end
      end
    end
  end

  function automatic bit expect_out(bit first_half);
    bit dcc;
    if (bypass) return first_half;
    if (force_hi && no_sync) return 1'b1;
    dcc = !dcc_off && (((m_hi + m_lo) % 2) == 1);
    return first_half ? (m_lvl | (dcc & m_prev)) : m_lvl;
  endfunction

  task automatic check(string t, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t out=%0b expected=%0b", t, $time, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (chk_en) check(tag, clk_out, expect_out(1'b1));
      @(negedge clk); #1;
      if (chk_en) check(tag, clk_out, expect_out(1'b0));
    end
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1.5; end
  endtask

  task automatic restart();
    sync_req = 1'b1; step(2); sync_req = 1'b0;
  endtask

  initial begin
    fork
      begin
        step(3);
        check("R1 reset level", clk_out, 1'b0);
        rst_n = 1'b1;
        chk_en = 1'b1;
        tag = "R1 free run"; step(6);

        tag = "R2/R3 count sweep";
        for (int h = 0; h < 16; h++) begin
          for (int l = 0; l < 16; l++) begin
            hi_cycles = CW'(h); lo_cycles = CW'(l);
            restart(); step(2 * (h + l + 2) + 1);
          end
        end

        tag = "R10 duty correction"; dcc_off = 1'b0;
        for (int h = 0; h < 16; h += 3) begin
          for (int l = 0; l < 16; l += 2) begin
            hi_cycles = CW'(h); lo_cycles = CW'(l);
            restart(); step(2 * (h + l + 2) + 1);
          end
        end
        hi_cycles = 4'd3; lo_cycles = 4'd2; restart(); step(5);
        start_hi = 1'b0; sync_req = 1'b1; step(1); sync_req = 1'b0; step(12);
        dcc_off = 1'b1;

        tag = "R9/R8/R5 phase offset";
        hi_cycles = 4'd2; lo_cycles = 4'd4;
        for (int p = 0; p < 16; p++) begin
          phase_ofs = CW'(p); start_hi = p[0];
          restart(); step(p + 14);
        end
        for (int k = 0; k < 9; k++) begin
          step(k); sync_req = 1'b1; step(1); sync_req = 1'b0; step(7);
        end
        phase_ofs = '0; start_hi = 1'b0;

        tag = "R6 sync ignored"; no_sync = 1'b1;
        for (int k = 0; k < 6; k++) begin
          step(k + 1); sync_req = 1'b1; step(3); sync_req = 1'b0;
        end
        step(10);

        tag = "R7 force honoured"; force_hi = 1'b1; step(12);
        no_sync = 1'b0; tag = "R7 force ignored without nosync";
        restart(); step(20);

        tag = "R4 bypass"; bypass = 1'b1; no_sync = 1'b1; step(10);
        sync_req = 1'b1; step(2); sync_req = 1'b0;
        bypass = 1'b0; force_hi = 1'b0; no_sync = 1'b0; step(10);

        tag = "R11 count change mid period";
        hi_cycles = 4'd5; lo_cycles = 4'd6; restart();
        for (int k = 0; k < 8; k++) begin
          step(3 + k);
          hi_cycles = CW'(k * 2 + 1); lo_cycles = CW'(15 - k);
        end
        step(60);
      end
      begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
      end
    join_any
    chk_en = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule